// File: doc/BRIEF.md
# Switching-Period Ripple Predictor

This block looks one switching cycle ahead for a three-phase, three-level inverter modulator. It takes the three signed duty references and predicts how far the inductor current of each phase moves away from its starting value during one carrier period. It then works out the period for the next cycle, so that the worst phase reaches the allowed ripple and goes no further. Each phase output steps between the positive rail and the neutral point when its duty is positive, and between the neutral point and the negative rail when its duty is negative. The pulses are centred in the period. Within each interval between two switching edges every phase voltage is constant, so each phase current follows a straight line. The block sorts the six edges into time order, walks through the intervals, sums slope times interval length, and keeps the running extremes.

A controller pulses `start` once per cycle, with the duties, nominal period, bus voltage, reciprocal inductance and ripple limit applied. The result arrives after a fixed number of clocks and is flagged by a one-cycle `valid` pulse. The result stays on the outputs until the next pulse. The controller uses `period_next` to program the carrier for the following cycle.

The control is a five-state machine:
- S_IDLE goes to S_SORT when `start` is sampled. The inputs are captured in that same cycle.
- S_SORT runs six odd/even compare-swap passes and then goes to S_INTEG.
- S_INTEG runs seven interval steps and then goes to S_SCALE.
- S_SCALE runs for a single cycle and goes to S_DIV.
- S_DIV runs 28 restoring-division steps and returns to S_IDLE, raising `valid` as it does so.

Top module: `ripple_period_predictor`

## Requirements
- R1: After reset, `valid` is 0, `ripple_max` is 0 and `period_next` equals TMAX (2047).
- R2: Each duty is clamped to the range -64..+64. In the following, time is counted in ticks, with one period equal to 128 ticks. A phase with clamped duty d holds level sign(d) for ticks t where 64-|d| <= t < 64+|d|, and holds level 0 for all other ticks.
- R3: For phase k, the slope term in a tick is 64*(3*l_k - (l_a+l_b+l_c)) - (3*d_k - (d_a+d_b+d_c)). The running sum of this term starts at 0. The peak P is the largest absolute value that any phase's running sum reaches within the period. At the end of the period, each phase's running sum is back at 0.
- R4: `ripple_max` = floor(P * vdc * linv * tnom / 2^16).
- R5: When `ripple_max` is nonzero, `period_next` = floor(tnom*limit / ripple_max), clamped to the range [TMIN=64, TMAX=2047].
- R6: When the predicted ripple is 0, `period_next` is TMAX. This happens, for example, when every duty is 0 or at ±full scale.
- R7: `valid` rises exactly 43 clock edges after the edge that samples `start`, counting that edge as the first. `valid` is high for one cycle only.
- R8: While a computation is in progress, `start` is ignored. It does not change the result in flight, and it produces no extra `valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| start | input | 1 | begin one prediction; sampled only when idle |
| duty_a | input | 8 | signed duty reference of phase a |
| duty_b | input | 8 | signed duty reference of phase b |
| duty_c | input | 8 | signed duty reference of phase c |
| tnom | input | 12 | nominal period |
| vdc | input | 8 | DC bus voltage |
| linv | input | 8 | reciprocal of the phase inductance |
| limit | input | 16 | allowed peak ripple |
| valid | output | 1 | one-cycle result strobe |
| ripple_max | output | 32 | predicted worst-phase ripple at the nominal period |
| period_next | output | 12 | period for the next cycle |

## Verification
The assertions check several properties on every cycle:
- the edge list is in time order when integration starts;
- each phase's running sum is back at zero at the end of the period;
- the running maximum never falls below zero and the running minimum never rises above zero;
- the captured duties hold steady while the block is busy;
- `valid` lasts one cycle, the period stays within its bounds, and a zero ripple selects TMAX.

The assertions cannot show that the numbers are right. Only the bench scenarios can do that: the exact ripple and period values over sweeps of the duty triple, the clamping of out-of-range duties, the fixed latency, and the fact that a `start` arriving while busy leaves no trace.

// File: rtl/rp_pkg.sv
package rp_pkg;
    parameter int DUTY_W = 8;
    localparam int DMAX  = 2 ** (DUTY_W - 2);
    localparam int TW    = $clog2(2 * DMAX + 1);
    localparam int NPH   = 3;
    localparam int NEDGE = 2 * NPH;

    typedef struct packed {
        logic [TW-1:0] t;
        logic          fall;
        logic [1:0]    ph;
    } sw_edge_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SORT,
        S_INTEG,
        S_SCALE,
        S_DIV
    } rp_state_e;
endpackage

// File: rtl/rp_edge_gen.sv
module rp_edge_gen
    import rp_pkg::*;
(
    input  logic signed [DUTY_W-1:0] duty   [NPH],
    output logic signed [DUTY_W-1:0] dclamp [NPH],
    output sw_edge_t                 edges  [NEDGE]
);
    for (genvar k = 0; k < NPH; k++) begin : g_ph
        logic [DUTY_W-1:0] mag;
        always_comb begin
            if (duty[k] > DUTY_W'(DMAX))
                dclamp[k] = DUTY_W'(DMAX);
            else if (duty[k] < -DUTY_W'(DMAX))
                dclamp[k] = -DUTY_W'(DMAX);
            else
                dclamp[k] = duty[k];
            mag = dclamp[k][DUTY_W-1] ? DUTY_W'(-dclamp[k]) : DUTY_W'(dclamp[k]);
            // pulse centred in the period: rise before centre, fall after
            edges[2*k]   = '{t: TW'(DMAX) - TW'(mag), fall: 1'b0, ph: 2'(k)};
            edges[2*k+1] = '{t: TW'(DMAX) + TW'(mag), fall: 1'b1, ph: 2'(k)};
        end
    end
endmodule

// File: rtl/rp_slope.sv
module rp_slope
    import rp_pkg::*;
#(
    parameter int SW = DUTY_W + 4
) (
    input  logic signed [1:0]        lv   [NPH],
    input  logic signed [DUTY_W-1:0] dref [NPH],
    input  logic signed [DUTY_W+1:0] dsum,
    output logic signed [SW-1:0]     term [NPH]
);
    logic signed [3:0] lsum;
    assign lsum = 4'(lv[0]) + 4'(lv[1]) + 4'(lv[2]);

    for (genvar k = 0; k < NPH; k++) begin : g_term
        // instantaneous level minus mean level, minus balanced average voltage
        assign term[k] = SW'(DMAX * (3 * int'(lv[k]) - int'(lsum))
                           - (3 * int'(dref[k]) - int'(dsum)));
    end
endmodule

// File: rtl/ripple_period_predictor.sv
module ripple_period_predictor
    import rp_pkg::*;
#(
    parameter int TNW  = 12,
    parameter int VW   = 8,
    parameter int LIW  = 8,
    parameter int LW   = 16,
    parameter int RSH  = 16,
    parameter int TMIN = 64,
    parameter int TMAX = 2047
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [DUTY_W-1:0] duty_a,
    input  logic signed [DUTY_W-1:0] duty_b,
    input  logic signed [DUTY_W-1:0] duty_c,
    input  logic [TNW-1:0]           tnom,
    input  logic [VW-1:0]            vdc,
    input  logic [LIW-1:0]           linv,
    input  logic [LW-1:0]            limit,
    output logic                     valid,
    output logic [TNW+VW+LIW+TW+DUTY_W+4-RSH-1:0] ripple_max,
    output logic [TNW-1:0]           period_next
);
    localparam int SW  = DUTY_W + 4;
    localparam int AW  = TW + DUTY_W + 4;
    localparam int KW  = VW + LIW + TNW;
    localparam int PRW = AW + KW;
    localparam int RW  = PRW - RSH;
    localparam int NW  = TNW + LW;
    localparam int CW  = $clog2(NW + NEDGE + 1);

    rp_state_e state, state_nx;
    logic [CW-1:0]            cnt;
    sw_edge_t                 edg     [NEDGE];
    sw_edge_t                 sort_nx [NEDGE];
    sw_edge_t                 gen_e   [NEDGE];
    logic signed [DUTY_W-1:0] din     [NPH];
    logic signed [DUTY_W-1:0] dcl     [NPH];
    logic signed [DUTY_W-1:0] d_q     [NPH];
    logic signed [DUTY_W+1:0] dsum_q;
    logic [VW-1:0]            vdc_q;
    logic [LIW-1:0]           linv_q;
    logic [TNW-1:0]           tnom_q;
    logic [LW-1:0]            lim_q;
    logic signed [1:0]        lv      [NPH];
    logic signed [SW-1:0]     term    [NPH];
    logic signed [AW-1:0]     acc     [NPH];
    logic signed [AW-1:0]     acc_nx  [NPH];
    logic signed [AW-1:0]     amax    [NPH];
    logic signed [AW-1:0]     amin    [NPH];
    logic [TW-1:0]            tprev, tcur, dlt;
    logic [AW-1:0]            peak;
    logic [PRW-1:0]           prod;
    logic [RW-1:0]            rip_q;
    logic [NW-1:0]            num_q, quo_nx, quo_q;
    logic [RW:0]              rem_q, rem_sh, rem_nx;
    logic                     ge;
    logic [TNW-1:0]           per_c;
    logic [$clog2(NEDGE)-1:0] eidx;

    assign din = '{duty_a, duty_b, duty_c};

    rp_edge_gen u_edges (.duty(din), .dclamp(dcl), .edges(gen_e));
    rp_slope #(.SW(SW)) u_slope (.lv(lv), .dref(d_q), .dsum(dsum_q), .term(term));

    // one odd/even transposition pass; rising edge wins a tie
    always_comb begin
        sort_nx = edg;
        for (int i = 0; i < NEDGE - 1; i++) begin
            if ((i % 2) == int'(cnt[0]) &&
                {edg[i].t, edg[i].fall} > {edg[i+1].t, edg[i+1].fall}) begin
                sort_nx[i]   = edg[i+1];
                sort_nx[i+1] = edg[i];
            end
        end
    end

    // interval step: end time, length and new running sums
    always_comb begin
        eidx = (cnt < CW'(NEDGE)) ? cnt[$clog2(NEDGE)-1:0] : '0;
        tcur = (cnt < CW'(NEDGE)) ? edg[eidx].t : TW'(2 * DMAX);
        dlt  = tcur - tprev;
        for (int k = 0; k < NPH; k++)
            acc_nx[k] = acc[k] + AW'(int'(term[k]) * int'(dlt));
    end

    // worst phase magnitude and scaled ripple
    always_comb begin
        peak = '0;
        for (int k = 0; k < NPH; k++) begin
            if (AW'(amax[k]) > peak)  peak = AW'(amax[k]);
            if (AW'(-amin[k]) > peak) peak = AW'(-amin[k]);
        end
        prod = PRW'(peak) * PRW'(vdc_q) * PRW'(linv_q) * PRW'(tnom_q);
    end

    // restoring division step and saturation of the final quotient
    always_comb begin
        rem_sh = {rem_q[RW-1:0], num_q[NW-1]};
        ge     = rem_sh >= {1'b0, rip_q};
        rem_nx = ge ? rem_sh - {1'b0, rip_q} : rem_sh;
        quo_nx = {quo_q[NW-2:0], ge};
        if (rip_q == '0 || quo_nx > NW'(TMAX))
            per_c = TNW'(TMAX);
        else if (quo_nx < NW'(TMIN))
            per_c = TNW'(TMIN);
        else
            per_c = quo_nx[TNW-1:0];
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_SORT;
            S_SORT:  if (cnt == CW'(NEDGE - 1)) state_nx = S_INTEG;
            S_INTEG: if (cnt == CW'(NEDGE)) state_nx = S_SCALE;
            S_SCALE: state_nx = S_DIV;
            S_DIV:   if (cnt == CW'(NW - 1)) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; valid <= 1'b0; ripple_max <= '0; period_next <= TNW'(TMAX);
            dsum_q <= '0; vdc_q <= '0; linv_q <= '0; tnom_q <= '0; lim_q <= '0;
            tprev <= '0; rip_q <= '0; num_q <= '0; rem_q <= '0; quo_q <= '0;
            for (int i = 0; i < NEDGE; i++) edg[i] <= '0;
            for (int k = 0; k < NPH; k++) begin
                d_q[k] <= '0; lv[k] <= '0; acc[k] <= '0; amax[k] <= '0; amin[k] <= '0;
            end
        end else begin
            valid <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    edg    <= gen_e;
                    d_q    <= dcl;
                    dsum_q <= (DUTY_W+2)'(dcl[0]) + (DUTY_W+2)'(dcl[1]) + (DUTY_W+2)'(dcl[2]);
                    vdc_q <= vdc; linv_q <= linv; tnom_q <= tnom; lim_q <= limit;
                    cnt <= '0; tprev <= '0;
                    for (int k = 0; k < NPH; k++) begin
                        lv[k] <= '0; acc[k] <= '0; amax[k] <= '0; amin[k] <= '0;
                    end
                end
                S_SORT: begin
                    edg <= sort_nx;
                    cnt <= (cnt == CW'(NEDGE - 1)) ? '0 : cnt + 1'b1;
                end
                S_INTEG: begin
                    tprev <= tcur;
                    for (int k = 0; k < NPH; k++) begin
                        acc[k] <= acc_nx[k];
                        if (acc_nx[k] > amax[k]) amax[k] <= acc_nx[k];
                        if (acc_nx[k] < amin[k]) amin[k] <= acc_nx[k];
                        if (cnt < CW'(NEDGE) && edg[eidx].ph == 2'(k))
                            lv[k] <= edg[eidx].fall ? 2'sb00 :
                                     (d_q[k] > 0) ? 2'sb01 :
                                     (d_q[k] < 0) ? 2'sb11 : 2'sb00;
                    end
                    cnt <= (cnt == CW'(NEDGE)) ? '0 : cnt + 1'b1;
                end
                S_SCALE: begin
                    rip_q <= prod[PRW-1:RSH];
                    num_q <= NW'(tnom_q) * NW'(lim_q);
                    rem_q <= '0; quo_q <= '0; cnt <= '0;
                end
                S_DIV: begin
                    num_q <= {num_q[NW-2:0], 1'b0};
                    rem_q <= rem_nx;
                    quo_q <= quo_nx;
                    cnt   <= cnt + 1'b1;
                    if (cnt == CW'(NW - 1)) begin
                        valid       <= 1'b1;
                        ripple_max  <= rip_q;
                        period_next <= per_c;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    a_r5_period_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (period_next >= TNW'(TMIN) && period_next <= TNW'(TMAX)));
    a_r6_zero_gives_max: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ripple_max == '0) |-> period_next == TNW'(TMAX));
    for (genvar k = 0; k < NPH; k++) begin : g_chk
        a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
            (state != S_IDLE && state_nx != S_IDLE) |=> $stable(d_q[k]));
        a_r3_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (state == S_SCALE) |-> acc[k] == '0);
        a_r3_extrema_sign: assert property (@(posedge clk) disable iff (!rst_n)
            (amax[k] >= 0 && amin[k] <= 0));
    end
    for (genvar i = 0; i < NEDGE - 1; i++) begin : g_ord
        a_r2_sorted: assert property (@(posedge clk) disable iff (!rst_n)
            (state == S_INTEG && cnt == '0) |->
            {edg[i].t, edg[i].fall} <= {edg[i+1].t, edg[i+1].fall});
    end
endmodule

// File: tb/tb_ripple_period_predictor.sv
module tb_ripple_period_predictor;
    localparam int DM   = 64;
    localparam int TMIN = 64;
    localparam int TMAX = 2047;
    localparam int LAT  = 43;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [7:0] da = '0, db = '0, dc = '0;
    logic [11:0] tnom = '0;
    logic [7:0]  vdc = '0, linv = '0;
    logic [15:0] limit = '0;
    logic        valid;
    logic [31:0] ripple_max;
    logic [11:0] period_next;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    ripple_period_predictor dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .duty_a(da), .duty_b(db), .duty_c(dc),
        .tnom(tnom), .vdc(vdc), .linv(linv), .limit(limit),
        .valid(valid), .ripple_max(ripple_max), .period_next(period_next));

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            failures++;
            $display("FAIL watchdog expired: actual=%0d cycles expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampd(input int d);
        return (d > DM) ? DM : (d < -DM) ? -DM : d;
    endfunction

    // R2/R3 model: tick-by-tick walk of the period
    function automatic longint model_peak(input int r0, input int r1, input int r2);
        int r[3];
        int lv[3];
        longint acc[3], mx[3], mn[3];
        longint pk;
        int rs, ls, term;
        r[0] = clampd(r0); r[1] = clampd(r1); r[2] = clampd(r2);
        rs = r[0] + r[1] + r[2];
        for (int k = 0; k < 3; k++) begin acc[k] = 0; mx[k] = 0; mn[k] = 0; end
        for (int t = 0; t < 2 * DM; t++) begin
            for (int k = 0; k < 3; k++) begin
                int a;
                a = (r[k] < 0) ? -r[k] : r[k];
                lv[k] = (a > 0 && t >= DM - a && t < DM + a) ? ((r[k] > 0) ? 1 : -1) : 0;
            end
            ls = lv[0] + lv[1] + lv[2];
            for (int k = 0; k < 3; k++) begin
                term = DM * (3 * lv[k] - ls) - (3 * r[k] - rs);
                acc[k] += term;
                if (acc[k] > mx[k]) mx[k] = acc[k];
                if (acc[k] < mn[k]) mn[k] = acc[k];
            end
        end
        pk = 0;
        for (int k = 0; k < 3; k++) begin
            if (mx[k] > pk) pk = mx[k];
            if (-mn[k] > pk) pk = -mn[k];
        end
        return pk;
    endfunction

    function automatic longint model_rip(input longint pk, input int v, input int li, input int tn);
        return (pk * v * li * tn) >>> 16;
    endfunction

    function automatic longint model_per(input longint rip, input int tn, input int lim);
        longint q;
        if (rip == 0) return TMAX;
        q = (longint'(tn) * lim) / rip;
        if (q > TMAX) return TMAX;
        if (q < TMIN) return TMIN;
        return q;
    endfunction

    task automatic apply(input int r0, input int r1, input int r2,
                         input int v, input int li, input int tn, input int lim);
        da = 8'(r0); db = 8'(r1); dc = 8'(r2);
        vdc = 8'(v); linv = 8'(li); tnom = 12'(tn); limit = 16'(lim);
    endtask

    task automatic run_case(input int r0, input int r1, input int r2,
                            input int v, input int li, input int tn, input int lim,
                            input bit poke);
        int n;
        longint pk, er, ep;
        @(negedge clk);
        apply(r0, r1, r2, v, li, tn, lim);
        start = 1'b1;
        n = 0;
        while (n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            if (poke && n == 5) begin
                apply(-r1, r2, -r0, v + 1, li, tn, lim / 2 + 1);
                start = 1'b1;   // R8: must be ignored while busy
            end
            if (valid) break;
        end
        start = 1'b0;
        pk = model_peak(r0, r1, r2);
        er = model_rip(pk, v, li, tn);
        ep = model_per(er, tn, lim);
        check("R7 latency", n, LAT);
        check("R3/R4 ripple", ripple_max, er);
        check(er == 0 ? "R6 period" : "R5 period", period_next, ep);
        @(negedge clk);
        check("R7 single pulse", valid, 0);
    endtask

    initial begin
        int vals[9] = '{-64, -48, -32, -16, 0, 16, 32, 48, 64};
        int v5[5]   = '{-64, -32, 0, 32, 64};
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", valid, 0);
        check("R1 ripple", ripple_max, 0);
        check("R1 period", period_next, TMAX);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R6 R7: sweep of duty triples
        foreach (vals[i]) foreach (vals[j]) foreach (vals[k])
            run_case(vals[i], vals[j], vals[k], 100, 4, 1000, 20000, 1'b0);

        // second configuration, coarser sweep
        foreach (v5[i]) foreach (v5[j]) foreach (v5[k])
            run_case(v5[i], v5[j], v5[k], 250, 200, 4000, 65535, 1'b0);

        // R6: every duty at zero or full scale gives zero ripple
        run_case(64, 0, -64, 100, 4, 1000, 20000, 1'b0);
        run_case(0, 0, 0, 100, 4, 1000, 20000, 1'b0);
        run_case(-64, -64, -64, 100, 4, 1000, 20000, 1'b0);

        // R2: out-of-range duties clamp to full scale, odd values
        run_case(100, -20, 7, 100, 4, 1000, 20000, 1'b0);
        run_case(-128, 127, 33, 100, 4, 1000, 20000, 1'b0);
        run_case(127, -128, 0, 100, 4, 1000, 20000, 1'b0);
        run_case(1, -1, 63, 100, 4, 1000, 300, 1'b0);

        // R8: start while busy is ignored, then no extra strobe
        run_case(40, -24, -16, 100, 4, 1000, 9000, 1'b1);
        begin
            int extra;
            extra = 0;
            repeat (60) begin
                @(negedge clk);
                if (valid) extra++;
            end
            check("R8 no extra valid", extra, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule